// File: doc/BRIEF.md
# Five-Field Interval Packet Classifier

This block assigns a rule number to each packet from five header fields: a 32-bit source address, a 32-bit destination address, a 16-bit source port, a 16-bit destination port and an 8-bit protocol. Each field is first reduced to a short segment index. The field values are split into contiguous, non-overlapping intervals, and the index names the interval that holds the value. The indices from all five fields are then joined into one address. That address reads a product table whose entry is the rule number for that combination of intervals. There is no per-rule comparison and no ternary match array.

The rule list is held as two independent sub-sets. Each sub-set has its own interval bounds and its own product table, and both are read on every key. When both sub-sets produce a hit, the lower rule number wins. The result code with every bit set means that no rule matched. Two packet ports share the stored tables and are classified at the same time. Each port accepts a new key on every clock cycle and returns its result a fixed three cycles later, with a valid flag aligned to the result. Software fills the interval bounds and the table entries through one write port, before traffic starts.

Top module: `tuple_classifier`

## Requirements
- R1: A port key is 104 bits wide, packed as {src addr[31:0], dst addr[31:0], src port[15:0], dst port[15:0], proto[7:0]}, with the protocol in the lowest bits. For each field of each sub-set, the segment index is the count of the 2^SEG_BITS-1 stored bounds that are less than or equal to the field value. The bounds are loaded in ascending order, so segment i spans [bound i-1, bound i - 1], segment 0 starts at zero and the last segment ends at the field maximum.
- R2: Within a sub-set, the product table address is the concatenation {src addr idx, dst addr idx, src port idx, dst port idx, proto idx}, with the source address index in the most significant bits. The entry read at that address is the sub-set's rule number.
- R3: A result with all RULE_W bits set (15 for the default width) means no rule matched. It is reported only when neither sub-set has a hit.
- R4: When both sub-sets hit, the smaller rule number is reported.
- R5: A result and its valid flag appear exactly three clock cycles after the key is sampled. The valid flag follows the key valid input of the same port.
- R6: The ports are classified independently against the shared tables. Each port's result depends only on its own key.
- R7: While reset is high, every valid flag is low. After reset, every bound holds the field maximum and every table entry holds the no-match code, so every key returns no-match.
- R8: A bound write (cfg_bnd_we) changes only the bound chosen by cfg_set (0 or 1), cfg_field (0 src addr, 1 dst addr, 2 src port, 3 dst port, 4 proto) and cfg_slot (slot j holds the lower bound of segment j+1; the all-ones slot is ignored). A table write (cfg_tbl_we) changes only entry cfg_addr of table cfg_set.
- R9: Each port accepts a key on every cycle without stalls, so back-to-back keys produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_i | input | NPORT*104 | Keys; port p occupies bits [p*104 +: 104] |
| key_vld_i | input | NPORT | Key valid, one bit per port |
| cfg_bnd_we | input | 1 | Bound write strobe |
| cfg_tbl_we | input | 1 | Product table write strobe |
| cfg_set | input | 1 | Sub-set selected for the write |
| cfg_field | input | 3 | Field selected for a bound write |
| cfg_slot | input | SEG_BITS | Bound slot selected for a bound write |
| cfg_addr | input | 5*SEG_BITS | Table entry selected for a table write |
| cfg_data | input | 32 | Write data; low bits are used for narrower targets |
| res_o | output | NPORT*RULE_W | Rule numbers; port p occupies bits [p*RULE_W +: RULE_W] |
| res_vld_o | output | NPORT | Result valid, one bit per port |

## Verification
The assertions assume that the write port is idle while keys are flowing and that the bounds of each field ascend. Under those conditions each result is the smaller of the two table reads from the cycle before, and the no-match code can only come from two no-match reads. The bench loads all configuration before it streams any keys. It writes ascending multiples of a power-of-two step, and after that it changes one bound to a value that still lies between its neighbours. The key sweep concentrates on interval edges, zero and the field maximum, and mixes in arithmetic filler values. Every result is compared with a linear first-match search over the rule list, using the interval values themselves.

// File: rtl/tcls_pkg.sv
package tcls_pkg;
   localparam int NFLD  = 5;
   localparam int KEY_W = 104;
   localparam int NSET  = 2;

   // width of field f: 0 src addr, 1 dst addr, 2 src port, 3 dst port, 4 proto
   function automatic int fld_w(input int f);
      case (f)
         0, 1:    return 32;
         2, 3:    return 16;
         default: return 8;
      endcase
   endfunction

   // lowest key bit of field f
   function automatic int fld_lsb(input int f);
      case (f)
         0:       return 72;
         1:       return 40;
         2:       return 24;
         3:       return 8;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/seg_map.sv
// Maps a field value to its interval index by counting the stored lower bounds
// that the value reaches. NPORT values are mapped in parallel.
module seg_map #(
   parameter int W     = 32,
   parameter int SB    = 2,
   parameter int NPORT = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [SB-1:0]    slot,
   input  logic [W-1:0]     wdata,
   input  logic [NPORT*W-1:0]  x,
   output logic [NPORT*SB-1:0] idx
);
   localparam int NB = (1 << SB) - 1;

   logic [W-1:0] bnd_q [NB];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < NB; j++) bnd_q[j] <= '1;
      end else begin
         for (int j = 0; j < NB; j++)
            if (we && slot == SB'(j)) bnd_q[j] <= wdata;
      end
   end

   always_comb begin
      idx = '0;
      for (int p = 0; p < NPORT; p++)
         for (int j = 0; j < NB; j++)
            if (x[p*W +: W] >= bnd_q[j]) idx[p*SB +: SB] = idx[p*SB +: SB] + 1'b1;
   end
endmodule

// File: rtl/prod_tbl.sv
// Product table: one write port, NPORT registered read ports.
module prod_tbl #(
   parameter int AW    = 10,
   parameter int DW    = 4,
   parameter int NPORT = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                we,
   input  logic [AW-1:0]       waddr,
   input  logic [DW-1:0]       wdata,
   input  logic [NPORT*AW-1:0] raddr,
   output logic [NPORT*DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
         rdata <= '1;
      end else begin
         if (we) mem[waddr] <= wdata;
         for (int p = 0; p < NPORT; p++) rdata[p*DW +: DW] <= mem[raddr[p*AW +: AW]];
      end
   end
endmodule

// File: rtl/prio_merge.sv
// Picks the higher-priority (numerically lower) rule; the all-ones miss code loses.
module prio_merge #(
   parameter int DW = 4
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);
   assign y = (a <= b) ? a : b;
endmodule

// File: rtl/tuple_classifier.sv
module tuple_classifier
   import tcls_pkg::*;
#(
   parameter int NPORT    = 2,
   parameter int SEG_BITS = 2,
   parameter int RULE_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NPORT*KEY_W-1:0]    key_i,
   input  logic [NPORT-1:0]          key_vld_i,
   input  logic                      cfg_bnd_we,
   input  logic                      cfg_tbl_we,
   input  logic                      cfg_set,
   input  logic [2:0]                cfg_field,
   input  logic [SEG_BITS-1:0]       cfg_slot,
   input  logic [NFLD*SEG_BITS-1:0]  cfg_addr,
   input  logic [31:0]               cfg_data,
   output logic [NPORT*RULE_W-1:0]   res_o,
   output logic [NPORT-1:0]          res_vld_o
);
   localparam int AW = NFLD * SEG_BITS;

   if (SEG_BITS < 1 || SEG_BITS > 4) begin : g_bad_seg
      $error("SEG_BITS must lie in 1..4");
   end
   if (RULE_W < 1 || RULE_W > 32) begin : g_bad_rule
      $error("RULE_W must lie in 1..32");
   end
   if (NPORT < 1) begin : g_bad_port
      $error("NPORT must be at least 1");
   end

   logic [NPORT-1:0][NSET-1:0][AW-1:0]     addr_c, addr_q;
   logic [NPORT-1:0][NSET-1:0][RULE_W-1:0] rule_q;
   logic [NPORT-1:0][RULE_W-1:0]           win_c, res_q;
   logic [NPORT-1:0]                       va_q, vb_q, vc_q;

   for (genvar s = 0; s < NSET; s++) begin : g_set
      for (genvar f = 0; f < NFLD; f++) begin : g_fld
         localparam int W   = fld_w(f);
         localparam int LSB = fld_lsb(f);
         logic [NPORT*W-1:0]        x_w;
         logic [NPORT*SEG_BITS-1:0] i_w;
         for (genvar p = 0; p < NPORT; p++) begin : g_prt
            assign x_w[p*W +: W] = key_i[p*KEY_W + LSB +: W];
            assign addr_c[p][s][(NFLD-1-f)*SEG_BITS +: SEG_BITS] = i_w[p*SEG_BITS +: SEG_BITS];
         end
         seg_map #(.W(W), .SB(SEG_BITS), .NPORT(NPORT)) u_seg (
            .clk   (clk),
            .rst   (rst),
            .we    (cfg_bnd_we && cfg_set == 1'(s) && cfg_field == 3'(f)),
            .slot  (cfg_slot),
            .wdata (cfg_data[W-1:0]),
            .x     (x_w),
            .idx   (i_w)
         );
      end

      logic [NPORT*AW-1:0]     ra_w;
      logic [NPORT*RULE_W-1:0] rd_w;
      for (genvar p = 0; p < NPORT; p++) begin : g_rd
         assign ra_w[p*AW +: AW] = addr_q[p][s];
         assign rule_q[p][s]     = rd_w[p*RULE_W +: RULE_W];
      end
      prod_tbl #(.AW(AW), .DW(RULE_W), .NPORT(NPORT)) u_tbl (
         .clk   (clk),
         .rst   (rst),
         .we    (cfg_tbl_we && cfg_set == 1'(s)),
         .waddr (cfg_addr),
         .wdata (cfg_data[RULE_W-1:0]),
         .raddr (ra_w),
         .rdata (rd_w)
      );
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_out
      prio_merge #(.DW(RULE_W)) u_mrg (
         .a (rule_q[p][0]),
         .b (rule_q[p][1]),
         .y (win_c[p])
      );
      assign res_o[p*RULE_W +: RULE_W] = res_q[p];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         res_q  <= '1;
         va_q   <= '0;
         vb_q   <= '0;
         vc_q   <= '0;
      end else begin
         addr_q <= addr_c;
         res_q  <= win_c;
         va_q   <= key_vld_i;
         vb_q   <= va_q;
         vc_q   <= vb_q;
      end
   end

   assign res_vld_o = vc_q;
endmodule

// File: rtl/tuple_classifier_chk.sv
module tuple_classifier_chk #(
   parameter int NPORT  = 2,
   parameter int NSET   = 2,
   parameter int RULE_W = 4
) (
   input logic                                  clk,
   input logic                                  rst,
   input logic [NPORT-1:0]                      key_vld,
   input logic [NPORT-1:0]                      res_vld,
   input logic [NPORT*RULE_W-1:0]               res,
   input logic [NPORT-1:0][NSET-1:0][RULE_W-1:0] rule
);
   localparam logic [RULE_W-1:0] MISS = '1;

   logic [1:0] since_q;
   always_ff @(posedge clk) begin
      if (rst) since_q <= '0;
      else if (since_q != 2'd3) since_q <= since_q + 2'd1;
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_p
      // R5: valid flag trails key valid by three cycles
      a_r5_vld_latency: assert property (@(posedge clk) disable iff (rst)
         (since_q == 2'd3) |-> (res_vld[p] == $past(key_vld[p], 3)));

      // R7: reset clears the valid flags
      a_r7_reset_clears: assert property (@(posedge clk)
         rst |=> !res_vld[p]);

      // R4: the reported rule is one of the two sub-set reads and no larger than either
      a_r4_merge_lower: assert property (@(posedge clk) disable iff (rst)
         (since_q != 2'd0 && res_vld[p]) |->
            ((res[p*RULE_W +: RULE_W] <= $past(rule[p][0])) &&
             (res[p*RULE_W +: RULE_W] <= $past(rule[p][1])) &&
             ((res[p*RULE_W +: RULE_W] == $past(rule[p][0])) ||
              (res[p*RULE_W +: RULE_W] == $past(rule[p][1])))));

      // R3: the miss code only when both sub-sets missed
      a_r3_miss_needs_both: assert property (@(posedge clk) disable iff (rst)
         (since_q != 2'd0 && res_vld[p] && res[p*RULE_W +: RULE_W] == MISS) |->
            ($past(rule[p][0]) == MISS && $past(rule[p][1]) == MISS));
   end
endmodule

bind tuple_classifier tuple_classifier_chk #(
   .NPORT (NPORT),
   .NSET  (tcls_pkg::NSET),
   .RULE_W(RULE_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .key_vld (key_vld_i),
   .res_vld (res_vld_o),
   .res     (res_o),
   .rule    (rule_q)
);

// File: tb/tuple_classifier_tb.sv
module tuple_classifier_tb;
   localparam int NP = 2;
   localparam int SB = 2;
   localparam int RW = 4;
   localparam int MISS = 15;
   localparam int NR = 10;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NP*104-1:0] key = '0;
   logic [NP-1:0]     kvld = '0;
   logic              bwe = 1'b0, twe = 1'b0, cset = 1'b0;
   logic [2:0]        cfld = '0;
   logic [SB-1:0]     cslot = '0;
   logic [5*SB-1:0]   caddr = '0;
   logic [31:0]       cdata = '0;
   logic [NP*RW-1:0]  res;
   logic [NP-1:0]     rvld;

   int checks = 0, fails = 0;
   longint bnd [2][5][3];
   int rlo [NR][5];
   int rhi [NR][5];
   longint kv [5];
   bit loaded = 0;
   string phase = "";
   bit ev [NP][4];
   int er [NP][4];
   string et [NP][4];

   tuple_classifier #(.NPORT(NP), .SEG_BITS(SB), .RULE_W(RW)) u_dut (
      .clk(clk), .rst(rst), .key_i(key), .key_vld_i(kvld),
      .cfg_bnd_we(bwe), .cfg_tbl_we(twe), .cfg_set(cset), .cfg_field(cfld),
      .cfg_slot(cslot), .cfg_addr(caddr), .cfg_data(cdata),
      .res_o(res), .res_vld_o(rvld));

   always #10 clk = ~clk;

   function automatic int fw(int f);
      return (f < 2) ? 32 : (f < 4) ? 16 : 8;
   endfunction
   function automatic longint fmask(int f);
      return (64'd1 << fw(f)) - 1;
   endfunction
   function automatic longint stp(int s, int f);
      return (s == 0) ? (64'd1 << (fw(f) - 2)) : (64'd1 << (fw(f) - 3));
   endfunction
   function automatic longint seg_lo(int s, int f, int i);
      return (i == 0) ? 0 : bnd[s][f][i-1];
   endfunction
   function automatic longint seg_hi(int s, int f, int i);
      return (i == 3) ? fmask(f) : bnd[s][f][i] - 1;
   endfunction
   // linear first-match over the rule list on interval values; sf<0 means all sets
   function automatic int first_hit(int sf);
      for (int r = 0; r < NR; r++) begin
         bit ok = 1;
         if (sf >= 0 && (r % 2) != sf) continue;
         for (int f = 0; f < 5; f++)
            if (kv[f] < seg_lo(r % 2, f, rlo[r][f]) || kv[f] > seg_hi(r % 2, f, rhi[r][f])) ok = 0;
         if (ok) return r;
      end
      return MISS;
   endfunction
   function automatic longint fval(int n, int f);
      int h = n * 13 + f * 7;
      int k = h % 6;
      int s = (h / 6) % 2;
      longint j = (h / 12) % 3 + 1;
      case (k)
         0: return 0;
         1: return fmask(f);
         2: return j * stp(s, f);
         3: return j * stp(s, f) - 1;
         default: return (longint'(n) * 40503 + f * 977 + longint'(n) * n * 31) & fmask(f);
      endcase
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", phase, req, act, exp);
      end
   endtask

   task automatic wr_bnd(int s, int f, int j, longint v);
      @(negedge clk);
      bwe = 1; cset = 1'(s); cfld = 3'(f); cslot = SB'(j); cdata = 32'(v);
      bnd[s][f][j] = v;
      @(negedge clk);
      bwe = 0;
   endtask

   task automatic load_all();
      for (int s = 0; s < 2; s++)
         for (int f = 0; f < 5; f++)
            for (int j = 0; j < 3; j++) wr_bnd(s, f, j, (j + 1) * stp(s, f));
      // product table compiled from segment index ranges (R2 address order)
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < 1024; a++) begin
            int e = MISS;
            for (int r = NR - 1; r >= 0; r--) begin
               bit ok = (r % 2) == s;
               for (int f = 0; f < 5; f++) begin
                  int ix = (a >> ((4 - f) * 2)) & 3;
                  if (ix < rlo[r][f] || ix > rhi[r][f]) ok = 0;
               end
               if (ok) e = r;
            end
            @(negedge clk);
            twe = 1; cset = 1'(s); caddr = 10'(a); cdata = 32'(e);
         end
      @(negedge clk);
      twe = 0;
      loaded = 1;
   endtask

   task automatic run_stream(int ncyc, int seed);
      for (int c = 0; c < ncyc + 3; c++) begin
         @(negedge clk);
         if (c >= 3) begin
            for (int p = 0; p < NP; p++) begin
               int sl = (c - 3) % 4;
               check(rvld[p] == ev[p][sl], $sformatf("R5 R9 valid port%0d", p), rvld[p], ev[p][sl]);
               if (ev[p][sl])
                  check(res[p*RW +: RW] == RW'(er[p][sl]), et[p][sl], res[p*RW +: RW], er[p][sl]);
            end
         end
         for (int p = 0; p < NP; p++) begin
            int sl = c % 4;
            if (c < ncyc) begin
               int n = seed + c * 2 + p;
               bit v = (n % 7) != 3;
               for (int f = 0; f < 5; f++) kv[f] = fval(n, f);
               key[p*104 +: 104] = {32'(kv[0]), 32'(kv[1]), 16'(kv[2]), 16'(kv[3]), 8'(kv[4])};
               kvld[p] = v;
               ev[p][sl] = v;
               if (!loaded) begin
                  er[p][sl] = MISS;
                  et[p][sl] = "R7 reset table miss";
               end else begin
                  int h0 = first_hit(0);
                  int h1 = first_hit(1);
                  er[p][sl] = first_hit(-1);
                  if (h0 != MISS && h1 != MISS) et[p][sl] = "R4 merge lower";
                  else if (h0 == MISS && h1 == MISS) et[p][sl] = "R3 miss code";
                  else et[p][sl] = "R1 R2 lookup";
               end
               if (p == 1) et[p][sl] = {"R6 port1 ", et[p][sl]};
            end else begin
               kvld[p] = 0;
               ev[p][sl] = 0;
            end
         end
      end
   endtask

   initial begin
      for (int r = 0; r < NR; r++)
         for (int f = 0; f < 5; f++) begin
            rlo[r][f] = (r * (f + 1) + f) % 4;
            rhi[r][f] = rlo[r][f] + (r + f) % 4;
            if (rhi[r][f] > 3) rhi[r][f] = 3;
         end
      for (int f = 0; f < 5; f++) begin
         rlo[8][f] = 0; rhi[8][f] = 3;
         rlo[9][f] = 0; rhi[9][f] = 3;
      end
      rlo[8][3] = 1; rhi[8][3] = 2;
      rlo[9][4] = 0; rhi[9][4] = 1;

      // R7: valid stays low while reset is held, even with keys offered
      kvld = '1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(rvld == '0, "R7 valid low in reset", rvld, 0);
      end
      kvld = '0;
      @(negedge clk);
      rst = 0;
      phase = "unloaded";
      run_stream(20, 5);
      load_all();
      phase = "main";
      run_stream(700, 11);
      // R8: move one proto bound of set 0; other bounds and set 1 keep theirs
      wr_bnd(0, 4, 0, 100);
      phase = "R8 after rewrite";
      run_stream(500, 3001);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule